// File: doc/BRIEF.md
# Variable-Length ADC Bank Unpacker

This block expands one front-end board's packed readout into 32 fixed-width samples. The board's bank arrives as a stream of 32-bit words over a valid/ready input. The leading word carries one width flag per channel. After it, the samples for the channels sit back to back as a single bit stream. Each sample is either 4 or 12 bits wide, so sample boundaries shift from bank to bank and often fall across two input words.

The unpacker records the flag word and gathers incoming words into a bit accumulator. It cuts one field per channel in ascending channel order. Each field goes out on a valid/ready output as a 12-bit value, together with its channel index and an end-of-bank marker. Once the last channel has gone out, any unused bits left in the final word are dropped, and the block waits for the next bank's flag word.

Top module: `adc_bank_unpacker`

## Requirements
- R1: The first word accepted after reset, or after a completed bank, is the flag word. Bit i of that word sets the width of channel i: 1 selects a 12-bit field and 0 selects a 4-bit field.
- R2: Fields follow the flag word with no padding between them. The first field starts at bit 0 of the second word, and each field's least significant bit comes first. A field that runs past bit 31 continues at bit 0 of the next word.
- R3: A 4-bit field is output zero-extended, so out_data[11:4] is 0. A 12-bit field is output unchanged.
- R4: Exactly 32 samples are output per bank, with out_chan counting 0, 1, ..., 31.
- R5: out_last is high on the channel 31 sample and low on every other sample.
- R6: When channel 31 is accepted, unused bits of the last data word are dropped. The next input word is then taken as a new flag word, and in_ready is high in the following cycle.
- R7: in_ready is low whenever out_valid is high. No data word is fetched while the current channel already has enough bits.
- R8: While out_valid is high and out_ready is low, out_data, out_chan and out_last stay unchanged and out_valid stays high.
- R9: A synchronous active-high reset empties the accumulator, sets the channel count to 0 and returns the block to waiting for a flag word, with out_valid low and in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Packed input word (flag word or data word) |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts the input word this cycle |
| out_data | output | 12 | Decoded sample, zero-extended if short |
| out_chan | output | 5 | Channel index of out_data |
| out_last | output | 1 | Marks channel 31, the final sample of the bank |
| out_valid | output | 1 | Output sample is valid |
| out_ready | input | 1 | Consumer accepts the sample this cycle |

## Verification
The bench runs banks back to back with these flag words: all short, all long, alternating in both phases, one half of each width, only the end channels long, and two irregular patterns. The uniform banks test each field width without any change of width. The alternating and irregular patterns make widths change at every possible alignment and make fields straddle word boundaries. Garbage one-bits are placed in the leftover bits of each final word, so a bank that fails to drop them corrupts the next flag word. Output backpressure, input gaps, and a reset partway through a bank test the stall, hold and restart behaviour.

// File: rtl/adcu_pkg.sv
package adcu_pkg;

    localparam int NUM_CH  = 32;
    localparam int WORD_W  = 32;
    localparam int SHORT_W = 4;
    localparam int LONG_W  = 12;
    localparam int ACC_W   = WORD_W + LONG_W;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int CNT_W   = $clog2(ACC_W + 1);

    typedef enum logic {
        ST_FLAG = 1'b0,
        ST_DATA = 1'b1
    } ustate_t;

    typedef struct packed {
        logic [ACC_W-1:0] bits;
        logic [CNT_W-1:0] fill;
    } acc_t;

    function automatic logic [CNT_W-1:0] field_len(input logic is_long);
        return is_long ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
    endfunction

endpackage

// File: rtl/adcu_bitacc.sv
module adcu_bitacc
    import adcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    input  logic [CNT_W-1:0]  pop_len,
    output logic [LONG_W-1:0] head,
    output logic [CNT_W-1:0]  fill
);

    acc_t q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            q <= '0;
        end else if (push) begin
            q.bits <= q.bits | (ACC_W'(push_word) << q.fill);
            q.fill <= q.fill + CNT_W'(WORD_W);
        end else if (pop) begin
            q.bits <= q.bits >> pop_len;
            q.fill <= q.fill - pop_len;
        end
    end

    assign head = q.bits[LONG_W-1:0];
    assign fill = q.fill;

endmodule

// File: rtl/adcu_ctrl.sv
module adcu_ctrl
    import adcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    input  logic              sample_take,
    output ustate_t           state,
    output logic [CH_W-1:0]   chan,
    output logic              cur_long,
    output logic              at_last
);

    logic [NUM_CH-1:0] width_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_FLAG;
            chan       <= '0;
            width_mask <= '0;
        end else if (state == ST_FLAG) begin
            if (word_valid) begin
                width_mask <= word[NUM_CH-1:0];
                chan       <= '0;
                state      <= ST_DATA;
            end
        end else if (sample_take) begin
            if (at_last) begin
                chan  <= '0;
                state <= ST_FLAG;
            end else begin
                chan <= chan + CH_W'(1);
            end
        end
    end

    assign cur_long = width_mask[chan];
    assign at_last  = (chan == CH_W'(NUM_CH - 1));

endmodule

// File: rtl/adcu_fmt.sv
module adcu_fmt
    import adcu_pkg::*;
(
    input  logic              is_long,
    input  logic [LONG_W-1:0] head,
    output logic [LONG_W-1:0] value,
    output logic [CNT_W-1:0]  need
);

    always_comb begin
        need  = field_len(is_long);
        value = is_long ? head : LONG_W'(head[SHORT_W-1:0]);
    end

endmodule

// File: rtl/adc_bank_unpacker.sv
module adc_bank_unpacker
    import adcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [LONG_W-1:0] out_data,
    output logic [CH_W-1:0]   out_chan,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready
);

    ustate_t           state;
    logic [CH_W-1:0]   chan;
    logic              cur_long;
    logic              at_last;
    logic [LONG_W-1:0] head;
    logic [CNT_W-1:0]  fill;
    logic [CNT_W-1:0]  need;
    logic [LONG_W-1:0] value;
    logic              have_field;
    logic              push;
    logic              pop;

    assign have_field = (fill >= need);
    assign in_ready   = (state == ST_FLAG) || !have_field;
    assign out_valid  = (state == ST_DATA) && have_field;
    assign push       = (state == ST_DATA) && in_valid && in_ready;
    assign pop        = out_valid && out_ready;
    assign out_data   = value;
    assign out_chan   = chan;
    assign out_last   = at_last;

    adcu_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .word_valid  (in_valid),
        .word        (in_data),
        .sample_take (pop),
        .state       (state),
        .chan        (chan),
        .cur_long    (cur_long),
        .at_last     (at_last)
    );

    adcu_bitacc u_acc (
        .clk       (clk),
        .rst       (rst),
        .clear     (pop && at_last),
        .push      (push),
        .push_word (in_data),
        .pop       (pop),
        .pop_len   (need),
        .head      (head),
        .fill      (fill)
    );

    adcu_fmt u_fmt (
        .is_long (cur_long),
        .head    (head),
        .value   (value),
        .need    (need)
    );

endmodule

// File: rtl/adcu_checker.sv
module adcu_checker
    import adcu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [LONG_W-1:0] out_data,
    input logic [CH_W-1:0]   out_chan,
    input logic              out_last,
    input logic              cur_long
);

    p_short_zero_ext_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !cur_long) |-> (out_data[LONG_W-1:SHORT_W] == '0));

    p_chan_step_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=>
            (out_chan == CH_W'($past(out_chan) + CH_W'(1))));

    p_last_on_end_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (out_chan == CH_W'(NUM_CH - 1))));

    p_flag_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    p_no_fetch_while_valid_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_last)));

endmodule

bind adc_bank_unpacker adcu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_chan  (out_chan),
    .out_last  (out_last),
    .cur_long  (cur_long)
);

// File: tb/adc_bank_unpacker_bench.sv
`timescale 1ns/1ps
module adc_bank_unpacker_bench;

    localparam int NB = 8;
    localparam int MAXW = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] out_data;
    logic [4:0]  out_chan;
    logic        out_last;
    logic        out_valid;
    logic        out_ready = 1'b0;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int nout = 0;

    logic [31:0] masks [NB];
    logic [31:0] words [NB][MAXW];
    int          nw    [NB];
    logic [11:0] expv  [NB][32];

    always #2.5 clk = ~clk;

    adc_bank_unpacker u_adc_bank_unpacker (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_chan(out_chan), .out_last(out_last),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build();
        logic [415:0] bits;
        int pos;
        masks[0] = 32'h0000_0000; masks[1] = 32'hFFFF_FFFF;
        masks[2] = 32'h5555_5555; masks[3] = 32'hAAAA_AAAA;
        masks[4] = 32'h0000_FFFF; masks[5] = 32'h8000_0001;
        masks[6] = 32'h1234_5678; masks[7] = 32'hF0F0_0F0F;
        for (int b = 0; b < NB; b++) begin
            bits = '1;
            pos = 0;
            for (int ch = 0; ch < 32; ch++) begin
                if (masks[b][ch]) begin
                    expv[b][ch] = 12'((b * 331 + ch * 129 + 7) % 4096);
                    for (int k = 0; k < 12; k++) bits[pos + k] = expv[b][ch][k];
                    pos += 12;
                end else begin
                    expv[b][ch] = 12'((b * 5 + ch * 3 + 1) % 16);
                    for (int k = 0; k < 4; k++) bits[pos + k] = expv[b][ch][k];
                    pos += 4;
                end
            end
            nw[b] = (pos + 31) / 32;
            words[b][0] = masks[b];
            for (int j = 0; j < nw[b]; j++) words[b][j + 1] = bits[32 * j +: 32];
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_data  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_bank(input int b, input int nwords);
        for (int j = 0; j < nwords; j++) begin
            if (j % 7 == 5) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            send_word(words[b][j]);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic consume(input int b0, input int nb, input bit stall_en);
        logic        held;
        logic [11:0] hd;
        logic [4:0]  hc;
        held = 1'b0;
        hd = '0;
        hc = '0;
        for (int b = b0; b < b0 + nb; b++) begin
            for (int ch = 0; ch < 32; ch++) begin
                bit done;
                done = 1'b0;
                while (!done) begin
                    @(negedge clk);
                    cyc++;
                    if (held)
                        chk(out_valid && out_data == hd && out_chan == hc,
                            "R8 hold under stall", int'(out_data), int'(hd));
                    if (out_valid)
                        chk(!in_ready, "R7 in_ready low while valid", int'(in_ready), 0);
                    out_ready = (stall_en && (cyc % 5 == 2 || cyc % 7 == 3)) ? 1'b0 : 1'b1;
                    held = out_valid && !out_ready;
                    hd = out_data;
                    hc = out_chan;
                    if (out_valid && out_ready) begin
                        done = 1'b1;
                        nout++;
                        chk(out_chan == 5'(ch), "R4 channel order", int'(out_chan), ch);
                        chk(out_data == expv[b][ch],
                            masks[b][ch] ? "R1 R2 long field value" : "R3 short field zero-extended",
                            int'(out_data), int'(expv[b][ch]));
                        chk(out_last == (ch == 31), "R5 last flag", int'(out_last), int'(ch == 31));
                    end
                end
            end
            @(negedge clk);
            out_ready = 1'b0;
            held = 1'b0;
            chk(in_ready && !out_valid, "R6 waits for new flag word", int'(in_ready), 1);
        end
    endtask

    initial begin
        build();
        fork
            begin
                repeat (3) @(negedge clk);
                chk(!out_valid, "R9 reset out_valid", int'(out_valid), 0);
                chk(in_ready, "R9 reset in_ready", int'(in_ready), 1);
                rst = 1'b0;
                fork
                    for (int b = 0; b < NB; b++) send_bank(b, nw[b] + 1);
                    consume(0, NB, (1'b1));
                join
                chk(nout == NB * 32, "R4 sample count", nout, NB * 32);
                // Partial bank, then reset in the middle of it (R9)
                out_ready = 1'b0;
                send_bank(0, 2);
                @(negedge clk);
                chk(out_valid && out_chan == 5'd0, "R9 partial bank ready", int'(out_valid), 1);
                rst = 1'b1;
                @(negedge clk);
                chk(!out_valid && in_ready, "R9 mid-bank reset clears", int'(out_valid), 0);
                rst = 1'b0;
                fork
                    send_bank(2, nw[2] + 1);
                    consume(2, 1, 1'b0);
                join
            end
            begin
                repeat (100000) @(posedge clk);
                nchk++;
                nfail++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", nout, NB * 32);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule